// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. A divider outside the block supplies a one-cycle `tick` strobe at eight times the bit rate. Each `tick` acts as one oversample. The line input passes through a two-flop synchronizer. A three-state controller then tracks the frame: waiting, start confirmation and data reception.

When the line falls, the receiver counts low oversamples. It accepts a start bit only if the line stays low up to the middle of that bit. Any earlier return to high counts as a glitch. After a start bit is accepted, each following bit is sampled once every eight ticks, close to its centre. Data bits arrive least significant first and shift into a shift register.

When the last data bit is taken, the assembled byte moves into the output register and `rx_valid` pulses for one clock. Two flags are reported:
- `err_overrun` records whether the host reported it was busy at that load.
- `err_frame` records whether the stop bit that follows was sampled low.

Top module: `serial_rx_os`

## Requirements
- R1: After reset, `rx_data` is 0 and `rx_valid`, `err_overrun` and `err_frame` are all 0.
- R2: Each frame with a confirmed start produces exactly one one-clock `rx_valid` pulse. In that pulse, `rx_data` bit 0 holds the first data bit received and bit 7 holds the last.
- R3: A start is confirmed only if the synchronized line is low on four consecutive ticks. If it returns high earlier, the block goes back to waiting and produces no `rx_valid` pulse.
- R4: After start confirmation, data bits are sampled every eight ticks. A frame sent at eight ticks per bit is recovered correctly for any byte value.
- R5: `err_overrun` takes the value of `host_busy` at the clock in which a byte is loaded. It holds that value until the next load.
- R6: `err_frame` is set to 1 when the stop-bit sample is 0, and to 0 when it is 1. It holds that value until the next stop-bit sample.
- R7: After a stop bit, a new start bit that begins right away is received. Back-to-back frames with a single stop bit each yield one byte each.
- R8: With `tick` held low, a low line causes no reception and no change to the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversample strobe, eight per bit time |
| rxd | input | 1 | Asynchronous serial line, idle high |
| host_busy | input | 1 | Host not ready to take a byte |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-clock pulse when `rx_data` is loaded |
| err_overrun | output | 1 | Host was busy at the last load |
| err_frame | output | 1 | Last stop bit was sampled low |

## Verification
A fault in the sample counter moves the sampling point away from the bit centre. The effect appears at the ports as a shifted or wrong byte at the next `rx_valid`, or as a missing pulse, within one frame time (80 ticks). A fault in the bit counter or the state transitions shows up as a wrong number of pulses, or as a flag that changes without a load or a stop sample. Glitch pulses and back-to-back frames expose any failure to return to waiting within a single frame.

// File: rtl/serial_rx_os.sv
module serial_rx_os #(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  input  logic                 host_busy,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 err_overrun,
  output logic                 err_frame
);
  localparam int SW  = $clog2(OVS);
  localparam int BW  = $clog2(DATA_BITS + 1);
  localparam logic [SW-1:0] MID  = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);
  localparam logic [BW-1:0] BLAST = BW'(DATA_BITS - 1);
  localparam logic [BW-1:0] BSTOP = BW'(DATA_BITS);

  typedef enum logic [1:0] {IDLE, START, RECV} st_t;
  st_t state;
  logic [1:0] sync;
  logic [SW-1:0] scnt;
  logic [BW-1:0] bcnt;
  logic [DATA_BITS-1:0] shreg;
  logic rx_s;
  logic [DATA_BITS-1:0] shifted;

  assign rx_s    = sync[1];
  assign shifted = {rx_s, shreg[DATA_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; scnt <= '0; bcnt <= '0; shreg <= '0;
      rx_data <= '0; rx_valid <= 1'b0; err_overrun <= 1'b0; err_frame <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        case (state)
          IDLE: if (!rx_s) begin state <= START; scnt <= SW'(1); end
          START:
            if (rx_s) begin
              state <= IDLE; scnt <= '0;
            end else if (scnt == MID) begin
              state <= RECV; scnt <= '0; bcnt <= '0;
            end else scnt <= scnt + 1'b1;
          RECV:
            if (scnt != LAST) scnt <= scnt + 1'b1;
            else begin
              scnt <= '0;
              if (bcnt == BSTOP) begin
                err_frame <= ~rx_s;
                state     <= IDLE;
              end else begin
                shreg <= shifted;
                bcnt  <= bcnt + 1'b1;
                if (bcnt == BLAST) begin
                  rx_data     <= shifted;
                  rx_valid    <= 1'b1;
                  err_overrun <= host_busy;
                end
              end
            end
          default: state <= IDLE;
        endcase
      end
    end
  end

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_confirm_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RECV && $past(state) == START) |-> ($past(scnt) == MID && !$past(rx_s)));
  assert_overrun_at_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(err_overrun));
  assert_frame_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_frame) |-> (state == IDLE && $past(state) == RECV));
  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(state) && $stable(rx_data)));
endmodule

// File: tb/tb_serial_rx_os.sv
module tb_serial_rx_os;
  logic clk = 0, rst_n = 0, tick = 0, rxd = 1, host_busy = 0, tick_en = 1;
  logic [7:0] rx_data;
  logic rx_valid, err_overrun, err_frame;
  int checks = 0, errors = 0, pulses = 0, div = 0;

  serial_rx_os dut (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .host_busy(host_busy), .rx_data(rx_data), .rx_valid(rx_valid),
    .err_overrun(err_overrun), .err_frame(err_frame));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    div <= (div == 3) ? 0 : div + 1;
    tick <= tick_en && (div == 3);
    if (rst_n && rx_valid) pulses <= pulses + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic v, input int ticks = 8);
    rxd = v;
    repeat (ticks * 4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop_v = 1, input int idle = 16);
    bit_time(0);
    for (int i = 0; i < 8; i++) bit_time(b[i]);
    if (stop_v) bit_time(1); else bit_time(0, 5);
    rxd = 1;
    repeat (idle * 4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 data", rx_data, 0);
    chk("R1 valid", rx_valid, 0);
    chk("R1 overrun", err_overrun, 0);
    chk("R1 frame", err_frame, 0);
  endtask

  task automatic t_patterns();
    logic [7:0] pats [4] = '{8'h55, 8'hA3, 8'h00, 8'hFF};
    foreach (pats[k]) begin
      int p0 = pulses;
      send(pats[k]);
      chk("R2 pulse count", pulses - p0, 1);
      chk("R4 data", rx_data, pats[k]);
      chk("R6 good stop", err_frame, 0);
    end
  endtask

  task automatic t_glitch();
    int p0 = pulses;
    bit_time(0, 2);
    bit_time(1, 20);
    chk("R3 glitch ignored", pulses - p0, 0);
    send(8'h3C);
    chk("R3 after glitch", rx_data, 8'h3C);
  endtask

  task automatic t_stop_err();
    int p0 = pulses;
    send(8'h81, 0);
    chk("R6 frame error", err_frame, 1);
    chk("R6 byte still loaded", rx_data, 8'h81);
    chk("R6 one pulse", pulses - p0, 1);
    send(8'h18);
    chk("R6 cleared", err_frame, 0);
  endtask

  task automatic t_busy();
    host_busy = 1;
    send(8'hC5);
    host_busy = 0;
    chk("R5 overrun set", err_overrun, 1);
    chk("R5 data", rx_data, 8'hC5);
    send(8'h2A);
    chk("R5 overrun cleared", err_overrun, 0);
  endtask

  task automatic t_back2back();
    int p0 = pulses;
    send(8'h96, 1, 0);
    send(8'h6B, 1, 16);
    chk("R7 two bytes", pulses - p0, 2);
    chk("R7 second byte", rx_data, 8'h6B);
  endtask

  task automatic t_no_tick();
    int p0 = pulses;
    tick_en = 0;
    repeat (3) @(negedge clk);
    rxd = 0;
    repeat (400) @(negedge clk);
    chk("R8 no pulse", pulses - p0, 0);
    chk("R8 data held", rx_data, 8'h6B);
    rxd = 1;
    repeat (8) @(negedge clk);
    tick_en = 1;
    repeat (64) @(negedge clk);
    send(8'hE7);
    chk("R8 resumes", rx_data, 8'hE7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (40) @(negedge clk);
    t_patterns();
    t_glitch();
    t_stop_err();
    t_busy();
    t_back2back();
    t_no_tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule